// File: doc/BRIEF.md
# Fill-Level Burst Arbiter with Direct Path

This block decides how data moves between a small on-chip ingress queue, a small on-chip egress queue and a large external burst memory that behaves as a deep store in between. It watches the occupancy of both queues and a count of bursts held in the external store. From these it decides when to ask the memory port for a burst that drains the ingress queue into memory, or for a burst that brings stored data back into the egress queue. Every burst moves a fixed 16 bytes, so its length in words is the burst byte count divided by the word width.

When the external store is empty and only a little data waits in the ingress queue, the block moves words straight from ingress to egress, one word per cycle, and skips the memory to keep latency short. As soon as any burst has been written to memory, the direct path stays shut until the store has drained again. This keeps the words in order. Only one burst is outstanding at a time, and write bursts win over read bursts so that the ingress queue cannot overflow. The block also keeps a sticky error flag that records any word pushed into a full ingress queue.

The block only drives the memory port's request/grant/done handshake. Command sequencing for the memory sits outside it. Words are popped on the queues by the surrounding logic, which follows the grant and the direct-path strobe.

Top module: `burst_traffic_arbiter`

## Requirements
- R1: In idle, if the ingress level is at least one burst and the store is not full, a request is raised on the next cycle with direction 1 (write, ingress to memory).
- R2: In idle, if the store count is nonzero, the egress free space (depth minus level) is at least one burst, and the ingress level is below one burst, a request is raised on the next cycle with direction 0 (read, memory to egress).
- R3: When the conditions of R1 and R2 would both hold, the write is chosen.
- R4: At most one burst is outstanding. The request stays high with a stable direction until the grant, and no new request is made until the burst-done strobe following that grant.
- R5: The stored-burst count rises by one on each completed write burst and falls by one on each completed read burst. It changes at no other time.
- R6: The full flag equals (stored count == capacity), and no write request starts while it is set.
- R7: The direct-path strobe is high exactly when the block is idle (no request, no burst in flight), the stored count is zero, the ingress level is between 1 and one burst minus one, and the egress level is below its depth. It is never high together with the request.
- R8: While the stored count is nonzero the direct-path strobe stays low.
- R9: The overflow flag sets on any cycle with an ingress push while the ingress level equals its depth, and it holds until reset.
- R10: After reset there is no request, no direct-path strobe, a count of zero, a clear full flag and a clear overflow flag.
- R11: With the ingress push rate held below the drain bandwidth the stimulus provides, the overflow flag never sets.
- R12: One burst is BURST_BYTES/WORD_BYTES words (8 words with the defaults 16 and 2). An ingress level of one burst minus one does not start a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_level | input | $clog2(IN_DEPTH+1) | Ingress queue occupancy in words |
| in_push | input | 1 | A word is being pushed into the ingress queue this cycle |
| out_level | input | $clog2(OUT_DEPTH+1) | Egress queue occupancy in words |
| burst_req | output | 1 | Burst request to the memory port |
| burst_dir | output | 1 | Burst direction: 1 write to memory, 0 read from memory |
| burst_grant | input | 1 | Memory port accepts the pending request |
| burst_done | input | 1 | Memory port finished the granted burst |
| byp_move | output | 1 | Move one word directly from ingress to egress this cycle |
| stored_cnt | output | $clog2(CAP_BURSTS+1) | Number of bursts held in external memory |
| store_full | output | 1 | Stored count is at capacity |
| in_ovf | output | 1 | Sticky ingress overflow flag |

## Verification
The assertions assume that the memory port raises the grant only while a request is pending and the done strobe only once per granted burst. They also assume that the queue levels it reports never exceed the queue depths. The bench keeps to this by modelling both queues itself. It saturates their levels, issues grant and done from its own record of the handshake phase, and pops a burst's worth of ingress words at a write grant. Random push and drain rates are chosen so that the egress drains faster than the ingress fills. Directed phases then force the store to capacity, drain it, and open the direct path.

// File: rtl/bta_pkg.sv
package bta_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_REQ  = 2'd1,
      ARB_BUSY = 2'd2
   } arb_state_t;

   localparam logic DIR_WRITE = 1'b1;
   localparam logic DIR_READ  = 1'b0;

endpackage

// File: rtl/bta_level_judge.sv
module bta_level_judge #(
   parameter int IN_DEPTH    = 32,
   parameter int OUT_DEPTH   = 32,
   parameter int BURST_WORDS = 8,
   parameter int BYPASS_EN   = 1,
   localparam int IN_LVL_W   = $clog2(IN_DEPTH + 1),
   localparam int OUT_LVL_W  = $clog2(OUT_DEPTH + 1)
) (
   input  logic [IN_LVL_W-1:0]  in_level,
   input  logic [OUT_LVL_W-1:0] out_level,
   input  logic                 store_empty,
   input  logic                 store_full,
   output logic                 wr_ok,
   output logic                 rd_ok,
   output logic                 byp_ok
);

   localparam logic [IN_LVL_W-1:0]  IN_THRESH = IN_LVL_W'(BURST_WORDS);
   localparam logic [OUT_LVL_W-1:0] OUT_MAX   = OUT_LVL_W'(OUT_DEPTH - BURST_WORDS);
   localparam logic [OUT_LVL_W-1:0] OUT_TOP   = OUT_LVL_W'(OUT_DEPTH);

   logic in_has_burst;
   logic out_has_room;

   always_comb begin
      in_has_burst = (in_level >= IN_THRESH);
      out_has_room = (out_level <= OUT_MAX);
      wr_ok        = in_has_burst && !store_full;
      rd_ok        = !store_empty && out_has_room && !in_has_burst;
   end

   generate
      if (BYPASS_EN != 0) begin : g_bypass
         always_comb begin
            byp_ok = store_empty && !in_has_burst
                     && (in_level != '0) && (out_level < OUT_TOP);
         end
      end else begin : g_no_bypass
         always_comb byp_ok = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bta_store_counter.sv
module bta_store_counter #(
   parameter int CAP_BURSTS = 1024,
   localparam int CNT_W     = $clog2(CAP_BURSTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(CAP_BURSTS);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (inc && !dec && (count_q != CAP)) begin
         count_q <= count_q + 1'b1;
      end else if (dec && !inc && (count_q != '0)) begin
         count_q <= count_q - 1'b1;
      end
   end

   always_comb begin
      count = count_q;
      empty = (count_q == '0);
      full  = (count_q == CAP);
   end

endmodule

// File: rtl/bta_sticky_flag.sv
module bta_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
      end
   end

   assign flag = flag_q;

endmodule

// File: rtl/burst_traffic_arbiter.sv
module burst_traffic_arbiter
   import bta_pkg::*;
#(
   parameter int WORD_BYTES  = 2,
   parameter int BURST_BYTES = 16,
   parameter int IN_DEPTH    = 32,
   parameter int OUT_DEPTH   = 32,
   parameter int CAP_BURSTS  = 1024,
   parameter int BYPASS_EN   = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [$clog2(IN_DEPTH+1)-1:0]     in_level,
   input  logic                              in_push,
   input  logic [$clog2(OUT_DEPTH+1)-1:0]    out_level,
   output logic                              burst_req,
   output logic                              burst_dir,
   input  logic                              burst_grant,
   input  logic                              burst_done,
   output logic                              byp_move,
   output logic [$clog2(CAP_BURSTS+1)-1:0]   stored_cnt,
   output logic                              store_full,
   output logic                              in_ovf
);

   localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;
   localparam int IN_LVL_W    = $clog2(IN_DEPTH + 1);
   localparam int OUT_LVL_W   = $clog2(OUT_DEPTH + 1);
   localparam int CNT_W       = $clog2(CAP_BURSTS + 1);
   localparam logic [IN_LVL_W-1:0] IN_TOP = IN_LVL_W'(IN_DEPTH);

   generate
      if (WORD_BYTES < 1 || BURST_BYTES % WORD_BYTES != 0) begin : g_bad_word
         $error("burst size must be a whole number of words");
      end
      if (BURST_WORDS < 2 || BURST_WORDS > IN_DEPTH || BURST_WORDS > OUT_DEPTH) begin : g_bad_burst
         $error("each queue must hold at least one burst of two or more words");
      end
      if (CAP_BURSTS < 1) begin : g_bad_cap
         $error("store capacity must be at least one burst");
      end
   endgenerate

   arb_state_t state_q;
   logic       dir_q;
   logic       wr_ok, rd_ok, byp_ok;
   logic       st_empty, st_full;
   logic       cnt_inc, cnt_dec;
   logic       finish;

   bta_level_judge #(
      .IN_DEPTH    (IN_DEPTH),
      .OUT_DEPTH   (OUT_DEPTH),
      .BURST_WORDS (BURST_WORDS),
      .BYPASS_EN   (BYPASS_EN)
   ) u_judge (
      .in_level    (in_level),
      .out_level   (out_level),
      .store_empty (st_empty),
      .store_full  (st_full),
      .wr_ok       (wr_ok),
      .rd_ok       (rd_ok),
      .byp_ok      (byp_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         dir_q   <= DIR_READ;
      end else begin
         unique case (state_q)
            ARB_IDLE: begin
               if (wr_ok) begin
                  state_q <= ARB_REQ;
                  dir_q   <= DIR_WRITE;
               end else if (rd_ok) begin
                  state_q <= ARB_REQ;
                  dir_q   <= DIR_READ;
               end
            end
            ARB_REQ: begin
               if (burst_grant) state_q <= ARB_BUSY;
            end
            ARB_BUSY: begin
               if (burst_done) state_q <= ARB_IDLE;
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   always_comb begin
      finish  = (state_q == ARB_BUSY) && burst_done;
      cnt_inc = finish && (dir_q == DIR_WRITE);
      cnt_dec = finish && (dir_q == DIR_READ);
   end

   bta_store_counter #(
      .CAP_BURSTS (CAP_BURSTS)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc),
      .dec   (cnt_dec),
      .count (stored_cnt),
      .empty (st_empty),
      .full  (st_full)
   );

   bta_sticky_flag u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (in_push && (in_level == IN_TOP)),
      .flag  (in_ovf)
   );

   always_comb begin
      burst_req  = (state_q == ARB_REQ);
      burst_dir  = dir_q;
      byp_move   = (state_q == ARB_IDLE) && byp_ok;
      store_full = st_full;
   end

endmodule

// File: rtl/bta_checker.sv
module bta_checker #(
   parameter int IN_LVL_W  = 6,
   parameter int OUT_LVL_W = 6,
   parameter int CNT_W     = 11
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [IN_LVL_W-1:0]  in_level,
   input logic                 in_push,
   input logic [OUT_LVL_W-1:0] out_level,
   input logic                 burst_req,
   input logic                 burst_dir,
   input logic                 burst_grant,
   input logic                 burst_done,
   input logic                 byp_move,
   input logic [CNT_W-1:0]     stored_cnt,
   input logic                 store_full,
   input logic                 in_ovf
);

   AST_READ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_req) && !burst_dir |-> $past(stored_cnt) != '0); // R2

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req && !burst_grant |=> burst_req); // R4

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req && !burst_grant |=> $stable(burst_dir)); // R4

   AST_CNT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stored_cnt) |-> $past(burst_done)); // R5

   AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_req) && burst_dir |-> !$past(store_full)); // R6

   AST_BYP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({burst_req, byp_move})); // R7

   AST_BYP_STORE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      byp_move |-> stored_cnt == '0); // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_ovf) |-> in_ovf); // R9

endmodule

bind burst_traffic_arbiter bta_checker #(
   .IN_LVL_W  (IN_LVL_W),
   .OUT_LVL_W (OUT_LVL_W),
   .CNT_W     (CNT_W)
) u_bta_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_level    (in_level),
   .in_push     (in_push),
   .out_level   (out_level),
   .burst_req   (burst_req),
   .burst_dir   (burst_dir),
   .burst_grant (burst_grant),
   .burst_done  (burst_done),
   .byp_move    (byp_move),
   .stored_cnt  (stored_cnt),
   .store_full  (store_full),
   .in_ovf      (in_ovf)
);

// File: tb/burst_traffic_arbiter_test.sv
module burst_traffic_arbiter_test;

   localparam int CLK_PERIOD = 10;
   localparam int IN_DEPTH   = 32;
   localparam int OUT_DEPTH  = 32;
   localparam int CAP        = 64;
   localparam int BW         = 16 / 2;
   localparam int PUSH_PCT   = 25;
   localparam int POP_PCT    = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] in_level = '0;
   logic       in_push = 1'b0;
   logic [5:0] out_level = '0;
   logic       burst_req, burst_dir, byp_move, store_full, in_ovf;
   logic       burst_grant = 1'b0;
   logic       burst_done = 1'b0;
   logic [6:0] stored_cnt;

   int checks = 0;
   int fails  = 0;

   // bench model of handshake phase and store
   int  m_st  = 0;   // 0 idle, 1 requesting, 2 in flight
   int  m_dir = 0;
   int  m_cnt = 0;
   int  m_in  = 0;
   int  m_out = 0;
   bit  m_prio = 0;
   bit  ovf_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_traffic_arbiter #(
      .WORD_BYTES  (2),
      .BURST_BYTES (16),
      .IN_DEPTH    (IN_DEPTH),
      .OUT_DEPTH   (OUT_DEPTH),
      .CAP_BURSTS  (CAP),
      .BYPASS_EN   (1)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_level    (in_level),
      .in_push     (in_push),
      .out_level   (out_level),
      .burst_req   (burst_req),
      .burst_dir   (burst_dir),
      .burst_grant (burst_grant),
      .burst_done  (burst_done),
      .byp_move    (byp_move),
      .stored_cnt  (stored_cnt),
      .store_full  (store_full),
      .in_ovf      (in_ovf)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_wr(input int lin, input int cnt);
      return (lin >= BW) && (cnt < CAP);
   endfunction

   function automatic bit exp_rd(input int lin, input int lout, input int cnt);
      return (cnt > 0) && (OUT_DEPTH - lout >= BW) && (lin < BW);
   endfunction

   function automatic bit exp_byp(input int st, input int lin, input int lout, input int cnt);
      return (st == 0) && (cnt == 0) && (lin > 0) && (lin < BW) && (lout < OUT_DEPTH);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));

      // reset state R10
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(burst_req == 1'b0, "R10 req", burst_req, 0);
      check(byp_move == 1'b0, "R10 byp", byp_move, 0);
      check(stored_cnt == 0, "R10 cnt", stored_cnt, 0);
      check(store_full == 1'b0, "R10 full", store_full, 0);
      check(in_ovf == 1'b0, "R10 ovf", in_ovf, 0);

      // directed overflow R9
      rst_n = 1'b1;
      in_level = 6'(IN_DEPTH - 1);
      out_level = 6'(OUT_DEPTH);
      in_push = 1'b1;
      @(negedge clk);
      check(in_ovf == 1'b0, "R9 no set below depth", in_ovf, 0);
      in_level = 6'(IN_DEPTH);
      @(negedge clk);
      check(in_ovf == 1'b1, "R9 set on push at depth", in_ovf, 1);
      in_push = 1'b0;
      in_level = '0;
      repeat (4) @(negedge clk);
      check(in_ovf == 1'b1, "R9 sticky", in_ovf, 1);

      // reset again, then model-driven phases
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(in_ovf == 1'b0, "R10 ovf after reset", in_ovf, 0);
      rst_n = 1'b1;
      in_level = '0;
      out_level = '0;

      for (int cyc = 0; cyc < 5400; cyc++) begin
         bit push, pop, grant, done;
         bit e_byp;
         string rtag;
         // phase selection
         if (cyc >= 3000 && cyc < 4000) begin
            m_in = (cyc % 7 == 0) ? BW - 1 : BW;  // fill store to capacity
            m_out = OUT_DEPTH;
         end else if (cyc >= 4000 && cyc < 5000) begin
            m_in = 0;                               // drain store
         end else if (cyc >= 5000) begin
            m_in = 3;                               // open the direct path
            m_out = cyc % 2;
         end
         push  = (cyc < 3000) && (($urandom % 100) < PUSH_PCT);
         pop   = (($urandom % 100) < POP_PCT);
         grant = (m_st == 1) && (($urandom % 3) == 0);
         done  = (m_st == 2) && (($urandom % 3) == 0);
         in_level    = 6'(m_in);
         out_level   = 6'(m_out);
         in_push     = push;
         burst_grant = grant;
         burst_done  = done;
         #1;
         // outputs vs model
         rtag = (m_st == 1) ? (m_prio ? "R3" : (m_dir == 1 ? "R1" : "R2")) : "R4";
         check(burst_req == (m_st == 1), rtag, burst_req, m_st == 1);
         if (m_st != 0) check(burst_dir == m_dir[0], rtag, burst_dir, m_dir);
         check(stored_cnt == m_cnt, "R5 count", stored_cnt, m_cnt);
         check(store_full == (m_cnt == CAP), "R6 full", store_full, m_cnt == CAP);
         e_byp = exp_byp(m_st, m_in, m_out, m_cnt);
         check(byp_move == e_byp, (m_cnt != 0) ? "R8 byp" : "R7 byp", byp_move, e_byp);
         // model next state
         if (m_st == 0) begin
            bit w, r;
            w = exp_wr(m_in, m_cnt);
            r = exp_rd(m_in, m_out, m_cnt);
            if (m_in == BW - 1 && cyc >= 3000 && cyc < 4000)
               check(!w, "R12 short of a burst", w, 0);
            m_prio = w && (m_cnt > 0) && (OUT_DEPTH - m_out >= BW);
            if (w) begin m_st = 1; m_dir = 1; end
            else if (r) begin m_st = 1; m_dir = 0; end
         end else if (m_st == 1) begin
            if (grant) begin
               m_st = 2;
               if (m_dir == 1) m_in -= BW;
            end
         end else begin
            if (done) begin
               m_st = 0;
               if (m_dir == 1) m_cnt++;
               else begin
                  m_cnt--;
                  m_out += BW;
               end
            end
         end
         if (e_byp) begin m_in--; m_out++; end
         if (push) begin
            if (in_level == 6'(IN_DEPTH)) ovf_seen = 1;
            else m_in++;
         end
         if (pop && m_out > 0) m_out--;
         if (cyc == 2999) begin
            check(in_ovf == 1'b0 && !ovf_seen, "R11 no overflow at rate", in_ovf, 0);
         end
         if (cyc == 3999) begin
            check(m_cnt == CAP && store_full, "R6 reached capacity", stored_cnt, CAP);
         end
         @(posedge clk);
         #1;
      end

      in_push = 1'b0;
      burst_grant = 1'b0;
      burst_done = 1'b0;
      @(negedge clk);
      check(in_ovf == 1'b0, "R11 flag clear at end", in_ovf, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule